// File: doc/BRIEF.md
# I2C Master SCL Divider Clock Generator

This block derives the serial clock of an I2C master from a faster system clock. A 16-bit divider word carries two byte-wide fields. One field sets how long SCL stays high and the other sets how long it stays low. Each phase lasts its field value plus a fixed two cycles, so the SCL period is (2+H)+(2+L) system clocks. The block also emits single-cycle phase strobes that a byte engine uses to time its work. The strobes mark the falling edge, the rising edge, and the midpoint of each phase, so that data can change in the middle of the low phase and be sampled in the middle of the high phase.

A run input starts and stops the clock. While stopped, SCL rests high and no strobes fire. Every start begins with a full low phase. Each phase takes its length from the divider word present on the clock edge that opens it, so a word written while the clock runs never shortens or stretches the phase in progress. With H=L=0x33 the period is 106 cycles (standard rate). With H=0x0A and L=0x0F the period is 29 cycles (fast rate).

Top module: `scl_divgen`

## Requirements
- R1: The divider word field in bits [15:8] sets the high phase and the field in bits [7:0] sets the low phase.
- R2: A high phase lasts exactly 2+H system clock cycles and a low phase exactly 2+L cycles, including the minimum case H=L=0, and no cycle is lost at a phase change.
- R3: The SCL period is (2+H)+(2+L) cycles. This gives 106 cycles for word 0x3333 and 29 cycles for word 0x0A0F.
- R4: During reset, and while run_i is low, scl_o is 1 and all four strobes are 0.
- R5: When run_i is high at a clock edge while the block is idle, scl_o is 0 after that edge and a full low phase follows.
- R6: Each phase takes its field from the divider word present on the clock edge that starts the phase. A change during a phase takes effect only at the next phase boundary.
- R7: scl_fall_o is 1 for exactly the first cycle of every low phase, and scl_rise_o is 1 for exactly the first cycle of every high phase.
- R8: mid_low_o is 1 in cycle floor((2+L)/2) of a low phase, and mid_high_o is 1 in cycle floor((2+H)/2) of a high phase. Cycles are counted from 0 at the phase start. These strobes never coincide with an edge strobe.
- R9: When run_i is low at a clock edge, scl_o is 1 after that edge, even in the middle of a phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 runs the SCL clock, 0 parks it high |
| div_word_i | input | 16 | Divider word: high field [15:8], low field [7:0] |
| scl_o | output | 1 | SCL level (1 = released high) |
| scl_rise_o | output | 1 | First cycle of a high phase |
| scl_fall_o | output | 1 | First cycle of a low phase |
| mid_high_o | output | 1 | Midpoint cycle of a high phase |
| mid_low_o | output | 1 | Midpoint cycle of a low phase |

## Verification
The divider runs with equal fields (0x3333) and with unequal fields (0x0A0F, 0x0500, 0x0005). Unequal fields reveal a swap of the high and low fields, which equal fields would hide. The zero word exercises the two-cycle minimum phase, where the midpoint and edge strobes sit closest together. A word change made in the middle of a low phase shows whether the new value leaks into the current phase. Stopping in the middle of a high phase and then restarting shows whether a start always opens with a complete low phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Fixed number of cycles added to every programmed phase field
    localparam int unsigned PHASE_OFFSET = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    // Strobe bundle handed from the decoder to the top
    typedef struct packed {
        logic scl;
        logic rise;
        logic fall;
        logic mid_high;
        logic mid_low;
    } scl_strobe_t;

endpackage

// File: rtl/scl_field_sel.sv
module scl_field_sel
    import scl_gen_pkg::*;
#(
    parameter int unsigned FIELD_W = 8,
    localparam int unsigned CNT_W  = FIELD_W + 1
) (
    input  logic [2*FIELD_W-1:0] div_word,
    output logic [CNT_W-1:0]     hi_len,
    output logic [CNT_W-1:0]     lo_len
);
    logic [FIELD_W-1:0] hi_field;
    logic [FIELD_W-1:0] lo_field;

    assign hi_field = div_word[2*FIELD_W-1:FIELD_W];
    assign lo_field = div_word[FIELD_W-1:0];

    always_comb begin
        hi_len = {1'b0, hi_field} + CNT_W'(PHASE_OFFSET);
        lo_len = {1'b0, lo_field} + CNT_W'(PHASE_OFFSET);
    end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_gen_pkg::*;
#(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    output scl_phase_e       phase,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] mid_idx
);
    typedef struct packed {
        scl_phase_e       ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] mid;
    } seq_t;

    seq_t cur, nxt;
    logic last_cycle;

    assign last_cycle = (cur.cnt == cur.len - CNT_W'(1));

    always_comb begin
        nxt = cur;
        if (!run) begin
            nxt.ph  = PH_IDLE;
            nxt.cnt = '0;
            nxt.len = '0;
            nxt.mid = '0;
        end else begin
            unique case (cur.ph)
                PH_IDLE: begin
                    nxt.ph  = PH_LOW;
                    nxt.cnt = '0;
                    nxt.len = lo_len;
                    nxt.mid = lo_len >> 1;
                end
                PH_LOW: begin
                    if (last_cycle) begin
                        nxt.ph  = PH_HIGH;
                        nxt.cnt = '0;
                        nxt.len = hi_len;
                        nxt.mid = hi_len >> 1;
                    end else begin
                        nxt.cnt = cur.cnt + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (last_cycle) begin
                        nxt.ph  = PH_LOW;
                        nxt.cnt = '0;
                        nxt.len = lo_len;
                        nxt.mid = lo_len >> 1;
                    end else begin
                        nxt.cnt = cur.cnt + CNT_W'(1);
                    end
                end
                default: begin
                    nxt.ph  = PH_IDLE;
                    nxt.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.ph  <= PH_IDLE;
            cur.cnt <= '0;
            cur.len <= '0;
            cur.mid <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign phase   = cur.ph;
    assign cnt     = cur.cnt;
    assign mid_idx = cur.mid;
endmodule

// File: rtl/scl_strobe_dec.sv
module scl_strobe_dec
    import scl_gen_pkg::*;
#(
    parameter int unsigned CNT_W = 9
) (
    input  scl_phase_e       phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] mid_idx,
    output scl_strobe_t      strb
);
    logic at_start;
    logic at_mid;

    assign at_start = (cnt == '0);
    assign at_mid   = (cnt == mid_idx);

    always_comb begin
        strb.scl      = (phase != PH_LOW);
        strb.fall     = (phase == PH_LOW)  && at_start;
        strb.rise     = (phase == PH_HIGH) && at_start;
        strb.mid_low  = (phase == PH_LOW)  && at_mid;
        strb.mid_high = (phase == PH_HIGH) && at_mid;
    end
endmodule

// File: rtl/scl_divgen.sv
module scl_divgen
    import scl_gen_pkg::*;
#(
    parameter int unsigned FIELD_W = 8,
    localparam int unsigned CNT_W  = FIELD_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_i,
    input  logic [2*FIELD_W-1:0] div_word_i,
    output logic                 scl_o,
    output logic                 scl_rise_o,
    output logic                 scl_fall_o,
    output logic                 mid_high_o,
    output logic                 mid_low_o
);
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] lo_len;
    scl_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mid_idx;
    scl_strobe_t      strb;

    scl_field_sel #(.FIELD_W(FIELD_W)) u_fields (
        .div_word (div_word_i),
        .hi_len   (hi_len),
        .lo_len   (lo_len)
    );

    scl_phase_seq #(.CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .run     (run_i),
        .hi_len  (hi_len),
        .lo_len  (lo_len),
        .phase   (phase),
        .cnt     (cnt),
        .mid_idx (mid_idx)
    );

    scl_strobe_dec #(.CNT_W(CNT_W)) u_dec (
        .phase   (phase),
        .cnt     (cnt),
        .mid_idx (mid_idx),
        .strb    (strb)
    );

    assign scl_o      = strb.scl;
    assign scl_rise_o = strb.rise;
    assign scl_fall_o = strb.fall;
    assign mid_high_o = strb.mid_high;
    assign mid_low_o  = strb.mid_low;
endmodule

// File: rtl/scl_divgen_chk.sv
module scl_divgen_chk (
    input logic clk,
    input logic rst,
    input logic run_i,
    input logic scl_o,
    input logic scl_rise_o,
    input logic scl_fall_o,
    input logic mid_high_o,
    input logic mid_low_o
);
    // R9
    stop_parks_high_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (scl_o && !scl_rise_o && !scl_fall_o && !mid_high_o && !mid_low_o));

    // R5
    start_opens_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run_i) |=> (scl_fall_o && !scl_o));

    // R7
    fall_marks_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_o) |-> scl_fall_o);

    // R7
    rise_marks_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && $past(run_i) && $rose(scl_o)) |-> scl_rise_o);

    // R8
    mid_low_level_chk: assert property (@(posedge clk) disable iff (rst)
        mid_low_o |-> !scl_o);

    // R8
    mid_high_level_chk: assert property (@(posedge clk) disable iff (rst)
        mid_high_o |-> scl_o);

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({scl_rise_o, scl_fall_o, mid_high_o, mid_low_o}));
endmodule

bind scl_divgen scl_divgen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run_i),
    .scl_o      (scl_o),
    .scl_rise_o (scl_rise_o),
    .scl_fall_o (scl_fall_o),
    .mid_high_o (mid_high_o),
    .mid_low_o  (mid_low_o)
);

// File: tb/sim_scl_divgen.sv
`timescale 1ns/1ps
module sim_scl_divgen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_i = 1'b0;
    logic [15:0] div_word_i = 16'h0000;
    logic scl_o, scl_rise_o, scl_fall_o, mid_high_o, mid_low_o;

    always #10 clk = ~clk;

    scl_divgen u0 (
        .clk(clk), .rst(rst), .run_i(run_i), .div_word_i(div_word_i),
        .scl_o(scl_o), .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o),
        .mid_high_o(mid_high_o), .mid_low_o(mid_low_o)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural model: 0 idle, 1 low, 2 high; countdown of remaining cycles
    int m_state = 0;
    int m_len = 0;
    int m_rem = 0;

    // measurements taken from the ports
    int cyc = 0;
    int low_run = 0, high_run = 0;
    int last_low = -1, last_high = -1;
    int prev_fall = -1, last_period = -1;
    int mid_low_pos = -1, mid_high_pos = -1;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic void model_edge(input bit r, input bit rs, input logic [15:0] d);
        if (rs || !r) begin
            m_state = 0; m_len = 0; m_rem = 0;
        end else if (m_state == 0) begin
            m_state = 1; m_len = 2 + int'(d[7:0]); m_rem = m_len - 1;
        end else if (m_rem == 0) begin
            if (m_state == 1) begin m_state = 2; m_len = 2 + int'(d[15:8]); end
            else              begin m_state = 1; m_len = 2 + int'(d[7:0]);  end
            m_rem = m_len - 1;
        end else begin
            m_rem--;
        end
    endfunction

    task automatic compare_now();
        int pos;
        bit e_scl, e_rise, e_fall, e_mh, e_ml;
        pos    = m_len - 1 - m_rem;
        e_scl  = (m_state != 1);
        e_fall = (m_state == 1) && (pos == 0);
        e_rise = (m_state == 2) && (pos == 0);
        e_ml   = (m_state == 1) && (pos == m_len / 2);
        e_mh   = (m_state == 2) && (pos == m_len / 2);
        chk("R2 scl level", int'(scl_o), int'(e_scl));
        chk("R7 fall strobe", int'(scl_fall_o), int'(e_fall));
        chk("R7 rise strobe", int'(scl_rise_o), int'(e_rise));
        chk("R8 mid_low strobe", int'(mid_low_o), int'(e_ml));
        chk("R8 mid_high strobe", int'(mid_high_o), int'(e_mh));
        // port-side measurements
        cyc++;
        if (scl_fall_o) begin
            if (high_run > 0) last_high = high_run;
            if (prev_fall >= 0) last_period = cyc - prev_fall;
            prev_fall = cyc;
            low_run = 1; high_run = 0;
        end else if (!scl_o) begin
            low_run++;
        end
        if (scl_rise_o) begin
            last_low = low_run; high_run = 1;
        end else if (scl_o && high_run > 0) begin
            high_run++;
        end
        if (mid_low_o)  mid_low_pos  = low_run - 1;
        if (mid_high_o) mid_high_pos = high_run - 1;
    endtask

    // inputs change at negedge; model follows the posedge; outputs checked at next negedge
    task automatic step(input bit r, input logic [15:0] d);
        run_i = r; div_word_i = d;
        @(posedge clk);
        model_edge(r, rst, d);
        @(negedge clk);
        compare_now();
    endtask

    task automatic steps(input int n, input bit r, input logic [15:0] d);
        for (int i = 0; i < n; i++) step(r, d);
    endtask

    task automatic until_fall(input logic [15:0] d);
        for (int i = 0; i < 600; i++) begin
            step(1'b1, d);
            if (scl_fall_o) break;
        end
    endtask

    task automatic until_rise(input logic [15:0] d);
        for (int i = 0; i < 600; i++) begin
            step(1'b1, d);
            if (scl_rise_o) break;
        end
    endtask

    task automatic settle(input logic [15:0] d);
        until_fall(d); until_fall(d); until_rise(d); until_fall(d);
    endtask

    initial begin
        @(negedge clk);
        steps(3, 1'b0, 16'h0000);
        // R4: reset state at ports
        chk("R4 scl in reset", int'(scl_o), 1);
        chk("R4 strobes in reset", int'({scl_rise_o, scl_fall_o, mid_high_o, mid_low_o}), 0);
        rst = 1'b0;
        steps(4, 1'b0, 16'h3333);
        chk("R4 scl idle", int'(scl_o), 1);

        // R5: start opens with full low phase
        step(1'b1, 16'h3333);
        chk("R5 first cycle low", int'(scl_o), 0);
        chk("R5 first cycle fall", int'(scl_fall_o), 1);
        until_rise(16'h3333);
        chk("R5 first low phase length", last_low, 53);
        settle(16'h3333);
        chk("R3 standard period", last_period, 106);
        chk("R2 standard high", last_high, 53);
        chk("R2 standard low", last_low, 53);

        // R1/R3/R8 fast setting
        settle(16'h0A0F);
        settle(16'h0A0F);
        chk("R3 fast period", last_period, 29);
        chk("R1 fast low from bits 7:0", last_low, 17);
        chk("R1 fast high from bits 15:8", last_high, 12);
        chk("R8 mid_low index", mid_low_pos, 8);
        chk("R8 mid_high index", mid_high_pos, 6);

        // R1 unequal single fields
        settle(16'h0500); settle(16'h0500);
        chk("R1 high field only: high", last_high, 7);
        chk("R1 high field only: low", last_low, 2);
        settle(16'h0005); settle(16'h0005);
        chk("R1 low field only: high", last_high, 2);
        chk("R1 low field only: low", last_low, 7);

        // R2 minimum phases
        settle(16'h0000); settle(16'h0000);
        chk("R2 min period", last_period, 4);
        chk("R2 min low", last_low, 2);
        chk("R2 min high", last_high, 2);
        chk("R8 min mid_low index", mid_low_pos, 1);

        // R6: change during low phase
        settle(16'h1010);
        until_fall(16'h1010);
        steps(3, 1'b1, 16'h1010);
        until_rise(16'h0202);
        chk("R6 low keeps old field", last_low, 18);
        until_fall(16'h0202);
        chk("R6 next high uses new field", last_high, 4);

        // R9: stop mid high, then restart
        until_rise(16'h0707);
        steps(2, 1'b1, 16'h0707);
        step(1'b0, 16'h0707);
        chk("R9 stop forces high", int'(scl_o), 1);
        steps(5, 1'b0, 16'h0707);
        chk("R4 idle no strobes", int'({scl_rise_o, scl_fall_o, mid_high_o, mid_low_o}), 0);
        prev_fall = -1; high_run = 0;
        step(1'b1, 16'h0707);
        chk("R9 restart fall", int'(scl_fall_o), 1);
        until_rise(16'h0707);
        chk("R9 restart full low", last_low, 9);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule